// File: doc/BRIEF.md
# Multi-Mode ADC Clock and Sample-Trigger Generator

This block runs from a fast system clock and produces two signals for an external converter. The first is a continuous master clock, obtained by an odd integer division of the system clock. The default is a divide-by-5 that turns 200 MHz into 40 MHz. The second is a short sample-trigger pulse. It fires once per frame, and a frame is 5, 8 or 13 master-clock periods long, chosen by a two-bit channel-mode select for one, two or three channels.

The pulse sits inside a master-clock period at a fixed phase. It therefore keeps a minimum gap after the master clock's rising edge, has a bounded width, and keeps a minimum gap between the master clock's falling edge and its own falling edge. The start phase and the length of the pulse are parameters. Elaboration stops when they break the edge-offset or width limits at the given system-clock period.

Once configured, the block runs on its own. A mode change waits for the next frame boundary. A rising edge on an asynchronous sync reference realigns the divider and the frame counter. The enable input only gates the trigger, so the master clock keeps running while the trigger is off.

Top module: `adc_clk_trig_gen`

## Requirements
- R1: The master clock repeats every 5 system-clock cycles.
- R2: In each master-clock period the master clock is high for 2 system-clock cycles and low for 3.
- R3: The trigger rises once per frame. A frame is 5 master periods (25 cycles) for modeSel 2'b00, 8 periods (40 cycles) for 2'b01 and 13 periods (65 cycles) for 2'b10.
- R4: Each trigger pulse is exactly 2 system-clock cycles wide.
- R5: The trigger rises 2 system-clock cycles after a master-clock rising edge.
- R6: The trigger falls 2 system-clock cycles after a master-clock falling edge, and it is never high while the master clock is high.
- R7: A new modeSel value takes effect only at the next frame boundary, so the frame in progress keeps its length.
- R8: With modeSel 2'b11 (reserved), no trigger is produced from the next frame onward, and the master clock keeps toggling.
- R9: While enable is low the trigger is low from the next cycle onward, and the master clock keeps toggling.
- R10: A rising edge on syncIn passes through a two-flop synchronizer and restarts the phase and frame counters. The first trigger of the new frame appears on the sixth system-clock edge, counting the edge that first samples syncIn high. Holding syncIn high causes no further realignment.
- R11: While rst is high both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 2 | Channel mode: 00 one, 01 two, 10 three, 11 reserved |
| enable | input | 1 | Trigger enable; the master clock is not gated |
| syncIn | input | 1 | Asynchronous sync reference, acts on its rising edge |
| mclkOut | output | 1 | Divided master clock for the converter |
| trigOut | output | 1 | Sample-trigger pulse |

## Verification
The hardest case to reach is a mode change in the middle of a frame. The new value must be held back until the boundary, and a sync edge must restart a frame at a known cycle. The bench writes modeSel a few cycles after an observed trigger edge. It then measures two consecutive trigger intervals, expecting the old frame length followed by the new one. For sync, it drives the edge at a fixed distance after a trigger, so that the old and realigned trigger times cannot coincide. It then counts edges to the first realigned pulse.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    MODE_ONE   = 2'b00,
    MODE_TWO   = 2'b01,
    MODE_THREE = 2'b10,
    MODE_RSVD  = 2'b11
  } chanMode_e;

  typedef struct packed {
    logic clkHigh;
    logic trigWin;
  } stepStrobe_t;

endpackage

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int DIV         = 5,
  parameter int HIGH_PHASES = 2,
  parameter int TRIG_START  = 2,
  parameter int TRIG_LEN    = 2,
  parameter int FRAME_ONE   = 5,
  parameter int FRAME_TWO   = 8,
  parameter int FRAME_THREE = 13
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  modeSel,
  input  logic        enable,
  input  logic        syncIn,
  output stepStrobe_t strobes
);

  localparam int MAXF12 = (FRAME_ONE > FRAME_TWO) ? FRAME_ONE : FRAME_TWO;
  localparam int MAXF   = (MAXF12 > FRAME_THREE) ? MAXF12 : FRAME_THREE;
  localparam int PW     = $clog2(DIV + 1);
  localparam int FW     = (MAXF > 1) ? $clog2(MAXF) : 1;

  localparam logic [PW-1:0] PH_LAST   = PW'(DIV - 1);
  localparam logic [PW-1:0] PH_HIGH   = PW'(HIGH_PHASES);
  localparam logic [PW-1:0] PH_TSTART = PW'(TRIG_START);
  localparam logic [PW-1:0] PH_TEND   = PW'(TRIG_START + TRIG_LEN);
  localparam logic [FW-1:0] F1_LAST   = FW'(FRAME_ONE - 1);
  localparam logic [FW-1:0] F2_LAST   = FW'(FRAME_TWO - 1);
  localparam logic [FW-1:0] F3_LAST   = FW'(FRAME_THREE - 1);

  logic [2:0]    syncPipe;
  logic          syncRise;
  logic [PW-1:0] phase;
  logic [FW-1:0] frame;
  logic [FW-1:0] frameLast;
  chanMode_e     activeMode;
  logic          phaseEnd;
  logic          boundary;

  // two synchronizer flops, then one history flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) syncPipe <= '0;
    else     syncPipe <= {syncPipe[1:0], syncIn};
  end
  assign syncRise = syncPipe[1] & ~syncPipe[2];

  always_comb begin
    case (activeMode)
      MODE_TWO:   frameLast = F2_LAST;
      MODE_THREE: frameLast = F3_LAST;
      default:    frameLast = F1_LAST;
    endcase
  end

  assign phaseEnd = (phase == PH_LAST);
  assign boundary = phaseEnd && (frame == frameLast);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= '0;
      frame      <= '0;
      activeMode <= MODE_RSVD;
    end else if (syncRise) begin
      phase      <= '0;
      frame      <= '0;
      activeMode <= chanMode_e'(modeSel);
    end else begin
      phase <= phaseEnd ? '0 : phase + 1'b1;
      if (phaseEnd) frame <= (frame == frameLast) ? '0 : frame + 1'b1;
      if (boundary) activeMode <= chanMode_e'(modeSel);
    end
  end

  always_comb begin
    strobes.clkHigh = (phase < PH_HIGH);
    strobes.trigWin = enable && (activeMode != MODE_RSVD) && (frame == '0) &&
                      (phase >= PH_TSTART) && (phase < PH_TEND);
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_LAST);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(boundary || syncRise) |=> $stable(activeMode));

endmodule

// File: rtl/adc_trig_datapath.sv
module adc_trig_datapath
  import adc_trig_pkg::*;
#(
  parameter int TRIG_LEN = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  stepStrobe_t strobes,
  output logic        mclkOut,
  output logic        trigOut
);

  localparam int RW = $clog2(TRIG_LEN + 2);

  logic [RW-1:0] highRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      mclkOut <= 1'b0;
      trigOut <= 1'b0;
    end else begin
      mclkOut <= strobes.clkHigh;
      trigOut <= strobes.trigWin;
    end
  end

  // observation counter for the pulse-width check
  always_ff @(posedge clk) begin
    if (rst)          highRun <= '0;
    else if (trigOut) highRun <= highRun + 1'b1;
    else              highRun <= '0;
  end

  // R4
  trig_len_chk: assert property (@(posedge clk) disable iff (rst)
    trigOut |-> (highRun < RW'(TRIG_LEN)));

  // R6
  trig_in_low_chk: assert property (@(posedge clk) disable iff (rst)
    trigOut |-> !mclkOut);

endmodule

// File: rtl/adc_clk_trig_gen.sv
module adc_clk_trig_gen
  import adc_trig_pkg::*;
#(
  parameter int DIV           = 5,
  parameter int HIGH_PHASES   = 2,
  parameter int TRIG_START    = 2,
  parameter int TRIG_LEN      = 2,
  parameter int FRAME_ONE     = 5,
  parameter int FRAME_TWO     = 8,
  parameter int FRAME_THREE   = 13,
  parameter int SYS_PERIOD_PS = 5000,
  parameter int RISE_GAP_PS   = 3000,
  parameter int FALL_GAP_PS   = 7000,
  parameter int PULSE_MIN_PS  = 5000,
  parameter int PULSE_MAX_PS  = 12500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic       enable,
  input  logic       syncIn,
  output logic       mclkOut,
  output logic       trigOut
);

  localparam int RISE_PS  = TRIG_START * SYS_PERIOD_PS;
  localparam int WIDTH_PS = TRIG_LEN * SYS_PERIOD_PS;
  localparam int FALL_PS  = (TRIG_START + TRIG_LEN - HIGH_PHASES) * SYS_PERIOD_PS;

  if (RISE_PS < RISE_GAP_PS) begin : g_bad_rise
    $error("trigger start too close to master-clock rising edge");
  end
  if (WIDTH_PS < PULSE_MIN_PS || WIDTH_PS > PULSE_MAX_PS) begin : g_bad_width
    $error("trigger width outside limits");
  end
  if (FALL_PS < FALL_GAP_PS) begin : g_bad_fall
    $error("trigger falls too soon after master-clock falling edge");
  end
  if (TRIG_START + TRIG_LEN > DIV) begin : g_bad_span
    $error("trigger pulse does not fit in one master-clock period");
  end

  stepStrobe_t strobes;

  adc_trig_ctrl #(
    .DIV(DIV), .HIGH_PHASES(HIGH_PHASES), .TRIG_START(TRIG_START),
    .TRIG_LEN(TRIG_LEN), .FRAME_ONE(FRAME_ONE), .FRAME_TWO(FRAME_TWO),
    .FRAME_THREE(FRAME_THREE)
  ) ctrl_i (
    .clk(clk), .rst(rst), .modeSel(modeSel), .enable(enable),
    .syncIn(syncIn), .strobes(strobes)
  );

  adc_trig_datapath #(.TRIG_LEN(TRIG_LEN)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .mclkOut(mclkOut), .trigOut(trigOut)
  );

  // R9
  trig_disable_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !trigOut);

endmodule

// File: tb/adc_clk_trig_gen_tb_top.sv
module adc_clk_trig_gen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic enable = 1'b1;
  logic syncIn = 1'b0;
  logic mclkOut, trigOut;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int lastMRise = 0;
  int lastMFall = 0;
  logic mPrev = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_clk_trig_gen dut_i (
    .clk(clk), .rst(rst), .modeSel(modeSel), .enable(enable),
    .syncIn(syncIn), .mclkOut(mclkOut), .trigOut(trigOut)
  );

  always @(negedge clk) begin
    if (mclkOut === 1'b1 && mPrev === 1'b0) lastMRise <= cyc;
    if (mclkOut === 1'b0 && mPrev === 1'b1) lastMFall <= cyc;
    mPrev <= mclkOut;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input bit isTrig);
    return isTrig ? trigOut : mclkOut;
  endfunction

  task automatic waitEdge(input bit isTrig, input logic lvl, output int t);
    do @(negedge clk); while (sig(isTrig) !== ~lvl);
    do @(negedge clk); while (sig(isTrig) !== lvl);
    t = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    rst = 1'b1;
    idle(4);
    check(mclkOut === 1'b0, "R11 mclk in reset", int'(mclkOut), 0);
    check(trigOut === 1'b0, "R11 trig in reset", int'(trigOut), 0);
    rst = 1'b0;
  endtask

  task automatic testClock();
    int r0, f0, r1;
    waitEdge(1'b0, 1'b1, r0);
    waitEdge(1'b0, 1'b0, f0);
    waitEdge(1'b0, 1'b1, r1);
    check(r1 - r0 == 5, "R1 master period", r1 - r0, 5);
    check(f0 - r0 == 2, "R2 master high time", f0 - r0, 2);
    check(r1 - f0 == 3, "R2 master low time", r1 - f0, 3);
  endtask

  task automatic testPeriod(input logic [1:0] m, input int expCyc);
    int t0, t1;
    modeSel = m;
    waitEdge(1'b1, 1'b1, t0);
    waitEdge(1'b1, 1'b1, t0);
    waitEdge(1'b1, 1'b1, t1);
    check(t1 - t0 == expCyc, "R3 trigger period", t1 - t0, expCyc);
  endtask

  task automatic testShape();
    int tr, tf, mr, mf;
    modeSel = 2'b00;
    waitEdge(1'b1, 1'b1, tr);
    mr = lastMRise;
    waitEdge(1'b1, 1'b0, tf);
    mf = lastMFall;
    check(tf - tr == 2, "R4 trigger width", tf - tr, 2);
    check(tr - mr == 2, "R5 rise after mclk rise", tr - mr, 2);
    check(tf - mf == 2, "R6 fall after mclk fall", tf - mf, 2);
  endtask

  task automatic testModeSwitch();
    int t0, t1, t2;
    modeSel = 2'b01;
    waitEdge(1'b1, 1'b1, t0);
    waitEdge(1'b1, 1'b1, t0);
    idle(10);
    modeSel = 2'b00;
    waitEdge(1'b1, 1'b1, t1);
    waitEdge(1'b1, 1'b1, t2);
    check(t1 - t0 == 40, "R7 current frame kept", t1 - t0, 40);
    check(t2 - t1 == 25, "R7 new frame length", t2 - t1, 25);
  endtask

  task automatic quietWindow(input string req);
    int highs = 0;
    int rises = 0;
    logic p = mclkOut;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (trigOut === 1'b1) highs++;
      if (mclkOut === 1'b1 && p === 1'b0) rises++;
      p = mclkOut;
    end
    check(highs == 0, req, highs, 0);
    check(rises == 20, req, rises, 20);
  endtask

  task automatic testReserved();
    modeSel = 2'b11;
    idle(70);
    quietWindow("R8 reserved mode");
    modeSel = 2'b00;
  endtask

  task automatic testEnable();
    int t;
    modeSel = 2'b00;
    idle(30);
    enable = 1'b0;
    idle(1);
    quietWindow("R9 enable low");
    enable = 1'b1;
    waitEdge(1'b1, 1'b1, t);
    check(trigOut === 1'b1, "R9 trigger resumes", int'(trigOut), 1);
  endtask

  task automatic testSync();
    int tr, c0, t1, t2;
    modeSel = 2'b10;
    waitEdge(1'b1, 1'b1, tr);
    waitEdge(1'b1, 1'b1, tr);
    idle(20);
    c0 = cyc;
    syncIn = 1'b1;
    waitEdge(1'b1, 1'b1, t1);
    check(t1 - c0 == 6, "R10 realigned trigger", t1 - c0, 6);
    waitEdge(1'b1, 1'b1, t2);
    check(t2 - t1 == 65, "R10 held sync no realign", t2 - t1, 65);
    syncIn = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testClock();
    testPeriod(2'b00, 25);
    testPeriod(2'b01, 40);
    testPeriod(2'b10, 65);
    testShape();
    testModeSwitch();
    testReserved();
    testEnable();
    testSync();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule